// File: doc/BRIEF.md
# Framed ADC Serial Port

This block is the device-side serial port of a sampling converter. An external host supplies a serial clock and two independent frame strobes. A falling edge on the write frame starts the capture of a 10-bit control word from the serial data input. A rising edge on the read frame arms a shift-out of the latest 10-bit conversion result. The serial pins are asynchronous to the block. A fast system clock oversamples them through two-flop synchronizers and finds their edges by comparing successive samples.

The write needs more serial clock pulses than bits kept, and the last pulse commits the word. The top bit of every control word is a device-address bit. A word is accepted only if that bit equals a strap input, so two devices can share one bus. The stored word is offered both whole and split into fields for the conversion engine.

The read counter ignores the serial clock until the read frame rises. A host that runs its clock and frame continuously therefore reads one aligned word per frame. After the tenth bit the data enable drops, and the port waits for the next frame.

Top module: `adc_frame_port`

## Requirements
- R1: After a write frame falls, the control word is taken from the data input on the next 10 falling serial-clock edges, most significant bit first. The field layout, from bit 9 down to bit 0, is: device address (bit 9), convert start (bit 8), external reference select (bit 7), power-down mode (bits 6:5), pseudo-differential select (bit 4), common select (bit 3), channel (bits 2:0).
- R2: The control register changes only on the 13th falling serial-clock edge of a write frame. It keeps its old value while fewer pulses have arrived. Data bits on pulses 11 to 13 are ignored.
- R3: A completed word whose bit 9 differs from the address strap is discarded, and the control register keeps its previous value. A word whose bit 9 matches is stored.
- R4: A new falling edge on the write frame restarts the write from bit 9, whatever the progress of an earlier write.
- R5: Rising serial-clock edges have no effect on the data output or its enable until a rising edge on the read frame arms the read. The result input is captured at arming.
- R6: Once armed, the result leaves the data output most significant bit first, one bit per rising serial-clock edge, starting with the first rising edge after arming. The data enable is high while these bits are driven.
- R7: On the 11th rising serial-clock edge of a read, the data enable drops and the read ends. Later rising edges leave it low until the read frame rises again. The data output is low whenever the enable is low.
- R8: After reset the control register is zero and the data output and its enable are low.
- R9: A write and a read may run in the same frame on a shared serial clock without affecting each other.
- R10: A pin change takes effect on the third rising system-clock edge after it is sampled: two synchronizer stages, then edge detection and the state update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data in (control word) |
| wr_frame_i | input | 1 | Write frame; falling edge starts a write |
| rd_frame_i | input | 1 | Read frame; rising edge arms a read |
| addr_strap_i | input | 1 | Device address strap |
| result_i | input | 10 | Latest conversion result |
| sdo_o | output | 1 | Serial data out |
| sdo_en_o | output | 1 | Drive enable for the data-out pad |
| ctrl_o | output | 10 | Stored control word |
| pkg_addr_o | output | 1 | Address field |
| conv_start_o | output | 1 | Convert-start field |
| ext_ref_o | output | 1 | External reference select field |
| pd_mode_o | output | 2 | Power-down mode field |
| pseudo_diff_o | output | 1 | Pseudo-differential select field |
| com_sel_o | output | 1 | Common select field |
| chan_o | output | 3 | Channel field |

## Verification
The write commit happens on a falling serial-clock edge, while read bits shift on rising edges. A frame in which both strobes change on the same system clock makes the two state machines start in the same cycle. They then run interleaved on one serial clock. The bench drives such a frame with both strobes moving together. It requires the shifted-out result and the newly stored control word to both match what each would be on its own. A behavioural model compares every output on every clock.

// File: rtl/afp_pkg.sv
package afp_pkg;
   localparam int CHAN_W = 3;

   typedef struct packed {
      logic              pkg_addr;
      logic              conv_start;
      logic              ext_ref;
      logic [1:0]        pd_mode;
      logic              pseudo_diff;
      logic              com_sel;
      logic [CHAN_W-1:0] chan;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   typedef enum int {
      SIG_SCLK = 0,
      SIG_DIN  = 1,
      SIG_WFR  = 2,
      SIG_RFR  = 3,
      SIG_NUM  = 4
   } sig_idx_e;
endpackage

// File: rtl/afp_sync.sv
module afp_sync #(
   parameter int N_SIG  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SIG-1:0] pins_i,
   output logic [N_SIG-1:0] lvl_o,
   output logic [N_SIG-1:0] rise_o,
   output logic [N_SIG-1:0] fall_o
);
   initial begin
      if (STAGES < 2) $error("afp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][N_SIG-1:0] stg_q;
   logic [N_SIG-1:0]             prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q  <= '0;
         prev_q <= '0;
      end else begin
         stg_q  <= {stg_q[STAGES-2:0], pins_i};
         prev_q <= stg_q[STAGES-1];
      end
   end

   assign lvl_o = stg_q[STAGES-1];

   for (genvar g = 0; g < N_SIG; g++) begin : g_edge
      assign rise_o[g] =  lvl_o[g] & ~prev_q[g];
      assign fall_o[g] = ~lvl_o[g] &  prev_q[g];
   end
endmodule

// File: rtl/afp_wr.sv
module afp_wr #(
   parameter int WORD_W    = 10,
   parameter int WR_PULSES = 13
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             start_i,
   input  logic                             sclk_fall_i,
   input  logic                             din_i,
   output logic [WORD_W-1:0]                word_o,
   output logic                             commit_o,
   output logic [$clog2(WR_PULSES+1)-1:0]   cnt_o
);
   localparam int CNT_W = $clog2(WR_PULSES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_PULSES - 1);
   localparam logic [CNT_W-1:0] KEEP = CNT_W'(WORD_W);

   logic              active_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] sh_q;

   assign commit_o = active_q & sclk_fall_i & ~start_i & (cnt_q == LAST);
   assign word_o   = sh_q;
   assign cnt_o    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         sh_q     <= '0;
      end else if (start_i) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
      end else if (active_q && sclk_fall_i) begin
         if (cnt_q < KEEP) sh_q <= {sh_q[WORD_W-2:0], din_i};
         if (cnt_q == LAST) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/afp_rd.sv
module afp_rd #(
   parameter int WORD_W = 10
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          arm_i,
   input  logic                          sclk_rise_i,
   input  logic [WORD_W-1:0]             result_i,
   output logic                          sdo_o,
   output logic                          sdo_en_o,
   output logic [$clog2(WORD_W+1)-1:0]   cnt_o
);
   localparam int CNT_W = $clog2(WORD_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W);

   logic              armed_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] sh_q;
   logic              sdo_q;
   logic              en_q;

   assign sdo_o    = sdo_q;
   assign sdo_en_o = en_q;
   assign cnt_o    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
         sh_q    <= '0;
         sdo_q   <= 1'b0;
         en_q    <= 1'b0;
      end else if (arm_i) begin
         armed_q <= 1'b1;
         cnt_q   <= '0;
         sh_q    <= result_i;
         sdo_q   <= 1'b0;
         en_q    <= 1'b0;
      end else if (armed_q && sclk_rise_i) begin
         if (cnt_q < LAST) begin
            sdo_q <= sh_q[WORD_W-1];
            sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
            en_q  <= 1'b1;
            cnt_q <= cnt_q + 1'b1;
         end else begin
            sdo_q   <= 1'b0;
            en_q    <= 1'b0;
            armed_q <= 1'b0;
            cnt_q   <= '0;
         end
      end
   end
endmodule

// File: rtl/adc_frame_port.sv
module adc_frame_port
   import afp_pkg::*;
#(
   parameter int WORD_W      = CTRL_W,
   parameter int WR_PULSES   = 13,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              sdi_i,
   input  logic              wr_frame_i,
   input  logic              rd_frame_i,
   input  logic              addr_strap_i,
   input  logic [WORD_W-1:0] result_i,
   output logic              sdo_o,
   output logic              sdo_en_o,
   output logic [WORD_W-1:0] ctrl_o,
   output logic              pkg_addr_o,
   output logic              conv_start_o,
   output logic              ext_ref_o,
   output logic [1:0]        pd_mode_o,
   output logic              pseudo_diff_o,
   output logic              com_sel_o,
   output logic [CHAN_W-1:0] chan_o
);
   localparam int WR_CNT_W = $clog2(WR_PULSES + 1);
   localparam int RD_CNT_W = $clog2(WORD_W + 1);

   initial begin
      if (WORD_W != CTRL_W) $error("adc_frame_port: WORD_W must equal the control layout width");
      if (WR_PULSES <= WORD_W) $error("adc_frame_port: WR_PULSES must exceed WORD_W");
   end

   logic [SIG_NUM-1:0] pins, lvl, rise, fall;
   assign pins[SIG_SCLK] = sclk_i;
   assign pins[SIG_DIN]  = sdi_i;
   assign pins[SIG_WFR]  = wr_frame_i;
   assign pins[SIG_RFR]  = rd_frame_i;

   afp_sync #(.N_SIG(SIG_NUM), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .pins_i(pins),
      .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
   );

   logic sclk_rise, sclk_fall, wr_start, rd_arm;
   assign sclk_rise = rise[SIG_SCLK];
   assign sclk_fall = fall[SIG_SCLK];
   assign wr_start  = fall[SIG_WFR];
   assign rd_arm    = rise[SIG_RFR];

   logic [WORD_W-1:0]   wr_word;
   logic                wr_commit;
   logic [WR_CNT_W-1:0] wr_cnt;
   logic [RD_CNT_W-1:0] rd_cnt;

   afp_wr #(.WORD_W(WORD_W), .WR_PULSES(WR_PULSES)) i_wr (
      .clk(clk), .rst_n(rst_n), .start_i(wr_start), .sclk_fall_i(sclk_fall),
      .din_i(lvl[SIG_DIN]), .word_o(wr_word), .commit_o(wr_commit), .cnt_o(wr_cnt)
   );

   afp_rd #(.WORD_W(WORD_W)) i_rd (
      .clk(clk), .rst_n(rst_n), .arm_i(rd_arm), .sclk_rise_i(sclk_rise),
      .result_i(result_i), .sdo_o(sdo_o), .sdo_en_o(sdo_en_o), .cnt_o(rd_cnt)
   );

   ctrl_t ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_commit && (wr_word[WORD_W-1] == addr_strap_i)) begin
         ctrl_q <= ctrl_t'(wr_word);
      end
   end

   assign ctrl_o        = WORD_W'(ctrl_q);
   assign pkg_addr_o    = ctrl_q.pkg_addr;
   assign conv_start_o  = ctrl_q.conv_start;
   assign ext_ref_o     = ctrl_q.ext_ref;
   assign pd_mode_o     = ctrl_q.pd_mode;
   assign pseudo_diff_o = ctrl_q.pseudo_diff;
   assign com_sel_o     = ctrl_q.com_sel;
   assign chan_o        = ctrl_q.chan;
endmodule

// File: rtl/afp_chk.sv
module afp_chk #(
   parameter int WORD_W    = 10,
   parameter int WR_PULSES = 13
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           sdo_o,
   input logic                           sdo_en_o,
   input logic [WORD_W-1:0]              ctrl_o,
   input logic                           addr_strap_i,
   input logic                           wr_commit,
   input logic                           sclk_rise,
   input logic                           rd_arm,
   input logic [$clog2(WORD_W+1)-1:0]    rd_cnt,
   input logic [$clog2(WR_PULSES+1)-1:0] wr_cnt
);
   // R2: control word moves only after a commit
   p_ctrl_on_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_o) |-> $past(wr_commit));

   // R2: write pulse counter stays in range
   p_wr_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt < WR_PULSES);

   // R3: a stored word carries the strapped address
   p_addr_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_o) |-> (ctrl_o[WORD_W-1] == $past(addr_strap_i)));

   // R6: enable comes up only on a serial clock rise
   p_en_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_en_o) |-> $past(sclk_rise));

   // R7: enable drops after the last bit or on re-arming
   p_en_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sdo_en_o) |-> (($past(rd_cnt) == WORD_W) || $past(rd_arm)));

   // R7: read counter bounded
   p_rd_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cnt <= WORD_W);

   // R7: data line is low while not driven
   p_quiet_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_en_o |-> !sdo_o);
endmodule

bind adc_frame_port afp_chk #(.WORD_W(WORD_W), .WR_PULSES(WR_PULSES)) i_afp_chk (
   .clk(clk), .rst_n(rst_n), .sdo_o(sdo_o), .sdo_en_o(sdo_en_o), .ctrl_o(ctrl_o),
   .addr_strap_i(addr_strap_i), .wr_commit(wr_commit), .sclk_rise(sclk_rise),
   .rd_arm(rd_arm), .rd_cnt(rd_cnt), .wr_cnt(wr_cnt)
);

// File: tb/test_adc_frame_port.sv
module test_adc_frame_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0, din = 1'b0, wfr = 1'b1, rfr = 1'b0, strap = 1'b1;
   logic [9:0] result = '0;
   logic       sdo_o, sdo_en_o;
   logic [9:0] ctrl_o;
   logic       pkg_addr_o, conv_start_o, ext_ref_o, pseudo_diff_o, com_sel_o;
   logic [1:0] pd_mode_o;
   logic [2:0] chan_o;

   always #5 clk = ~clk;

   adc_frame_port i_adc_frame_port (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(din), .wr_frame_i(wfr),
      .rd_frame_i(rfr), .addr_strap_i(strap), .result_i(result),
      .sdo_o(sdo_o), .sdo_en_o(sdo_en_o), .ctrl_o(ctrl_o),
      .pkg_addr_o(pkg_addr_o), .conv_start_o(conv_start_o), .ext_ref_o(ext_ref_o),
      .pd_mode_o(pd_mode_o), .pseudo_diff_o(pseudo_diff_o), .com_sel_o(com_sel_o),
      .chan_o(chan_o)
   );

   int n_chk = 0, n_fail = 0, c_chk = 0, c_fail = 0, wd_fail = 0;
   bit done = 0, cmp_on = 0;

   // behavioural reference model, updated on every rising clock
   bit [3:0] hs, hd, ht, hr;
   int m_wact, m_wcnt, m_wsh, m_ctrl, m_ract, m_rcnt, m_rsh, m_sdo, m_en;

   always @(posedge clk) begin
      if (!rst_n) begin
         hs = 0; hd = 0; ht = 0; hr = 0;
         m_wact = 0; m_wcnt = 0; m_wsh = 0; m_ctrl = 0;
         m_ract = 0; m_rcnt = 0; m_rsh = 0; m_sdo = 0; m_en = 0;
      end else begin
         hs = {hs[2:0], sclk}; hd = {hd[2:0], din};
         ht = {ht[2:0], wfr};  hr = {hr[2:0], rfr};
         if (ht[3] && !ht[2]) begin
            m_wact = 1; m_wcnt = 0;
         end else if (m_wact == 1 && hs[3] && !hs[2]) begin
            if (m_wcnt < 10) m_wsh = ((m_wsh << 1) | hd[2]) & 'h3FF;
            if (m_wcnt == 12) begin
               m_wact = 0; m_wcnt = 0;
               if (((m_wsh >> 9) & 1) == int'(strap)) m_ctrl = m_wsh;
            end else m_wcnt++;
         end
         if (!hr[3] && hr[2]) begin
            m_ract = 1; m_rcnt = 0; m_rsh = result; m_sdo = 0; m_en = 0;
         end else if (m_ract == 1 && !hs[3] && hs[2]) begin
            if (m_rcnt < 10) begin
               m_sdo = (m_rsh >> 9) & 1; m_rsh = (m_rsh << 1) & 'h3FF;
               m_en = 1; m_rcnt++;
            end else begin
               m_sdo = 0; m_en = 0; m_ract = 0; m_rcnt = 0;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_on && !done) begin
         c_chk += 3;
         if (int'(sdo_o) != m_sdo || int'(sdo_en_o) != m_en || int'(ctrl_o) != m_ctrl) begin
            c_fail++;
            $display("FAIL R10 at %0t: sdo/en/ctrl actual %0d/%0d/%0h expected %0d/%0d/%0h",
                     $time, sdo_o, sdo_en_o, ctrl_o, m_sdo, m_en, m_ctrl);
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one frame: optional write and read strobes, npulse serial clock pulses
   task automatic frame(input bit do_w, input bit do_r, input logic [9:0] w, input int npulse,
                        output logic [9:0] got, output bit en_any, output bit en_after);
      got = '0; en_any = 0; en_after = 0;
      if (do_w) wfr = 1'b0;
      if (do_r) rfr = 1'b1;
      waitn(6);
      for (int i = 0; i < npulse; i++) begin
         din  = (i < 10) ? w[9-i] : 1'b1;
         sclk = 1'b1;
         waitn(5);
         if (i < 10) got[9-i] = sdo_o;
         if (sdo_en_o) en_any = 1;
         if (i == 10) en_after = sdo_en_o;
         sclk = 1'b0;
         waitn(3);
      end
      waitn(6);
      wfr = 1'b1; rfr = 1'b0;
      waitn(6);
   endtask

   task automatic summary();
      int tot, bad;
      tot = n_chk + c_chk + wd_fail;
      bad = n_fail + c_fail + wd_fail;
      $display("%0d/%0d checks passed", tot - bad, tot);
   endtask

   initial begin
      logic [9:0] got;
      bit ea, eaft;
      waitn(3);
      rst_n = 1'b1;
      waitn(1);
      cmp_on = 1;
      // R8 reset state
      chk("R8 ctrl", ctrl_o, 0);
      chk("R8 en", sdo_en_o, 0);
      chk("R8 sdo", sdo_o, 0);

      // R1 full write, field decode
      frame(1, 0, 10'h2D3, 13, got, ea, eaft);
      chk("R1 ctrl", ctrl_o, 'h2D3);
      chk("R1 chan", chan_o, 3);
      chk("R1 pd_mode", pd_mode_o, 2);
      chk("R1 ext_ref", ext_ref_o, 1);
      chk("R1 conv_start", conv_start_o, 0);

      // R2 only 12 pulses: no commit
      frame(1, 0, 10'h355, 12, got, ea, eaft);
      chk("R2 short write", ctrl_o, 'h2D3);
      // R4 restart after unfinished write
      frame(1, 0, 10'h355, 13, got, ea, eaft);
      chk("R4 restart", ctrl_o, 'h355);
      frame(1, 0, 10'h3FF, 5, got, ea, eaft);
      frame(1, 0, 10'h30C, 13, got, ea, eaft);
      chk("R4 restart mid word", ctrl_o, 'h30C);

      // R3 address mismatch then match
      frame(1, 0, 10'h0AA, 13, got, ea, eaft);
      chk("R3 mismatch kept", ctrl_o, 'h30C);
      strap = 1'b0;
      waitn(2);
      frame(1, 0, 10'h0AA, 13, got, ea, eaft);
      chk("R3 match stored", ctrl_o, 'h0AA);

      // R5 clock without read frame
      result = 10'h2C9;
      frame(0, 0, 10'h000, 3, got, ea, eaft);
      chk("R5 no arm", ea, 0);
      // R6 / R7 read
      frame(0, 1, 10'h000, 11, got, ea, eaft);
      chk("R6 result bits", got, 'h2C9);
      chk("R7 en after 11th", eaft, 0);
      frame(0, 0, 10'h000, 3, got, ea, eaft);
      chk("R7 idle after read", ea, 0);

      // R9 concurrent write and read
      result = 10'h1B6;
      frame(1, 1, 10'h07E, 13, got, ea, eaft);
      chk("R9 read bits", got, 'h1B6);
      chk("R9 ctrl", ctrl_o, 'h07E);

      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         wd_fail = 1;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule